// File: doc/BRIEF.md
# Hidden Configuration Register Window for a Disk Timing Controller

This block hides a small bank of timing and mode registers behind the byte and word ports of a disk task file. While the bank is hidden, every access behaves as a plain task-file access. A stub data byte stands in for the drive. Software reveals the bank with a fixed key sequence: two word reads at offset 1 in a row, then a byte write of 0x03 at offset 2. After that, byte accesses at base plus an index land on the internal registers. A byte write of 0x83 at offset 2 hides the bank again.

The bank holds two timing sets, A and B, each with a read-cycle byte and a write-cycle byte. It also holds a control byte, a miscellaneous byte, and a read-only strap byte. The strap byte reports the bus clock rate. Set B can only be reached after a special control write made while the bank is hidden. Bit 0 of the miscellaneous byte then steers the timing indices to set B. The control byte decides whether drive 1 runs on set B or shares set A with drive 0. The block drives the timing values for each drive, together with the miscellaneous byte and the clock-rate strap, on output ports.

Top module: `ide_cfg_window`

## Requirements
- R1: Synchronous reset does the following: it hides the bank, puts the key tracker at idle, sets all four timing bytes to 0xFF (slowest), clears control, miscellaneous, the stub byte and the set-B enable, and samples the strap pin.
- R2: The bank opens after two word reads at offset 1 in a row, followed by a byte write of 0x03 at offset 2. A third or later word read at offset 1 keeps the tracker armed.
- R3: While the bank is hidden, any other access resets the key tracker to idle. Clock cycles with neither strobe set leave the tracker unchanged.
- R4: While the bank is hidden, every read returns the stub byte. The stub byte holds the data of the last write made while hidden, at any offset and of either size.
- R5: While the bank is open, a byte read at index 0, 1, 3, 5 or 6 returns the addressed register. A byte read at any other index returns 0x00, and so does any word read.
- R6: While the bank is open, a byte write of 0x83 at offset 2 hides it. The following have no effect: a byte write of any other value at offset 2, and any word write.
- R7: Strap bit 0 holds the strap pin value sampled in reset (1 = 25 MHz bus, 0 = 33 MHz). The other strap bits read 0. Writes to index 5 are ignored. The bit also drives `clk25_sel`.
- R8: A byte write at index 0 sets the read-cycle byte and one at index 1 sets the write-cycle byte. Both go to set B when miscellaneous bit 0 is 1 and set B is enabled, and to set A otherwise. Reads at these indices follow the same selection.
- R9: A byte write of 0xC0 at offset 3 while the bank is hidden enables set B. The enable stays set until reset.
- R10: Drive 0 always uses set A. Drive 1 uses set B when the control byte equals 0x85, and set A for any other control value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Offset from the task-file base |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_word | input | 1 | 1 = 16-bit access, 0 = byte access |
| bus_wdata | input | 8 | Write data (low byte) |
| bus_rdata | output | 8 | Read data, valid in the strobe cycle |
| strap_clk25 | input | 1 | Bus clock strap pin, sampled in reset |
| win_open | output | 1 | Configuration bank visible |
| drv0_rd_tim | output | 8 | Read-cycle timing for drive 0 |
| drv0_wr_tim | output | 8 | Write-cycle timing for drive 0 |
| drv1_rd_tim | output | 8 | Read-cycle timing for drive 1 |
| drv1_wr_tim | output | 8 | Write-cycle timing for drive 1 |
| misc_cfg | output | 8 | Miscellaneous register contents |
| clk25_sel | output | 1 | Latched clock strap |

## Verification
Two functions can act on the same cycle. A write made while the bank is hidden always lands in the stub byte. The same write may also be the step that completes the key, or a 0xC0 write at offset 3 that enables set B, and that write also breaks a key sequence in progress. The bench provokes both cases. It reads the stub byte back afterwards and then checks whether the bank opened or whether set B can be reached. A broken key (a byte read between the word reads) must leave the stub updated while the bank stays hidden.

// File: rtl/cfgwin_pkg.sv
package cfgwin_pkg;
    parameter int unsigned DW = 8;
    parameter int unsigned AW = 3;

    localparam logic [AW-1:0] IDX_RDTIM  = AW'(0);
    localparam logic [AW-1:0] IDX_WRTIM  = AW'(1);
    localparam logic [AW-1:0] IDX_CTRL   = AW'(3);
    localparam logic [AW-1:0] IDX_STRAP  = AW'(5);
    localparam logic [AW-1:0] IDX_MISC   = AW'(6);

    localparam logic [AW-1:0] OFS_UNLK_RD = AW'(1);
    localparam logic [AW-1:0] OFS_KEY     = AW'(2);
    localparam logic [AW-1:0] OFS_BEN     = AW'(3);

    localparam logic [DW-1:0] KEY_OPEN   = DW'(8'h03);
    localparam logic [DW-1:0] KEY_CLOSE  = DW'(8'h83);
    localparam logic [DW-1:0] KEY_BEN    = DW'(8'hC0);
    localparam logic [DW-1:0] CTRL_SPLIT = DW'(8'h85);
    localparam logic [DW-1:0] TIM_SLOW   = '1;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_ONE  = 2'd1,
        SEQ_TWO  = 2'd2
    } seq_e;

    typedef struct packed {
        logic          rd;
        logic          wr;
        logic          word;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
    } bus_req_t;

    typedef struct packed {
        logic [DW-1:0] rd;
        logic [DW-1:0] wr;
    } timing_t;

    function automatic logic is_byte_wr(bus_req_t r, logic [AW-1:0] a, logic [DW-1:0] d);
        return r.wr && !r.word && (r.addr == a) && (r.data == d);
    endfunction
endpackage

// File: rtl/cfgwin_unlock.sv
module cfgwin_unlock
    import cfgwin_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  bus_req_t req,
    output logic     win_open
);
    seq_e seq_q;
    logic open_q;
    logic access, rd_hit, open_hit, close_hit;

    always_comb begin
        access    = req.rd || req.wr;
        rd_hit    = req.rd && !req.wr && req.word && (req.addr == OFS_UNLK_RD);
        open_hit  = is_byte_wr(req, OFS_KEY, KEY_OPEN);
        close_hit = is_byte_wr(req, OFS_KEY, KEY_CLOSE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            seq_q  <= SEQ_IDLE;
            open_q <= 1'b0;
        end else if (access) begin
            if (open_q) begin
                seq_q <= SEQ_IDLE;
                if (close_hit) open_q <= 1'b0;
            end else if (rd_hit) begin
                seq_q <= (seq_q == SEQ_IDLE) ? SEQ_ONE : SEQ_TWO;
            end else begin
                seq_q <= SEQ_IDLE;
                if (seq_q == SEQ_TWO && open_hit) open_q <= 1'b1;
            end
        end
    end

    assign win_open = open_q;

    // R2
    open_after_key_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(open_q) |-> ($past(seq_q) == SEQ_TWO));

    // R6
    close_key_chk: assert property (@(posedge clk) disable iff (rst)
        (open_q && close_hit) |=> !open_q);

    // R3
    word_wr_breaks_chk: assert property (@(posedge clk) disable iff (rst)
        (!open_q && req.wr && req.word) |=> (seq_q == SEQ_IDLE && !open_q));
endmodule

// File: rtl/cfgwin_regs.sv
module cfgwin_regs
    import cfgwin_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  bus_req_t      req,
    input  logic          win_open,
    input  logic          strap_pin,
    output logic [DW-1:0] rdata,
    output timing_t       set_a,
    output timing_t       set_b,
    output logic [DW-1:0] ctrl,
    output logic [DW-1:0] misc,
    output logic          strap
);
    timing_t       set_a_q, set_b_q;
    logic [DW-1:0] ctrl_q, misc_q, stub_q;
    logic          bank_b_q, strap_q;
    logic          sel_b, bw_open;

    always_comb begin
        sel_b   = misc_q[0] && bank_b_q;
        bw_open = win_open && req.wr && !req.word;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            set_a_q  <= '{rd: TIM_SLOW, wr: TIM_SLOW};
            set_b_q  <= '{rd: TIM_SLOW, wr: TIM_SLOW};
            ctrl_q   <= '0;
            misc_q   <= '0;
            stub_q   <= '0;
            bank_b_q <= 1'b0;
            strap_q  <= strap_pin;
        end else if (bw_open) begin
            unique case (req.addr)
                IDX_RDTIM: if (sel_b) set_b_q.rd <= req.data; else set_a_q.rd <= req.data;
                IDX_WRTIM: if (sel_b) set_b_q.wr <= req.data; else set_a_q.wr <= req.data;
                IDX_CTRL:  ctrl_q <= req.data;
                IDX_MISC:  misc_q <= req.data;
                default:   ;
            endcase
        end else if (!win_open && req.wr) begin
            stub_q <= req.data;
            if (is_byte_wr(req, OFS_BEN, KEY_BEN)) bank_b_q <= 1'b1;
        end
    end

    always_comb begin
        rdata = '0;
        if (!win_open) begin
            rdata = stub_q;
        end else if (!req.word) begin
            unique case (req.addr)
                IDX_RDTIM: rdata = sel_b ? set_b_q.rd : set_a_q.rd;
                IDX_WRTIM: rdata = sel_b ? set_b_q.wr : set_a_q.wr;
                IDX_CTRL:  rdata = ctrl_q;
                IDX_STRAP: rdata = {{(DW-1){1'b0}}, strap_q};
                IDX_MISC:  rdata = misc_q;
                default:   rdata = '0;
            endcase
        end
    end

    assign set_a = set_a_q;
    assign set_b = set_b_q;
    assign ctrl  = ctrl_q;
    assign misc  = misc_q;
    assign strap = strap_q;

    // R7
    strap_hold_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> $stable(strap_q));

    // R9
    bank_b_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        bank_b_q |=> bank_b_q);

    // R8
    set_a_rd_wr_chk: assert property (@(posedge clk) disable iff (rst)
        (bw_open && req.addr == IDX_RDTIM && !sel_b) |=> (set_a_q.rd == $past(req.data)));

    // R4
    stub_capture_chk: assert property (@(posedge clk) disable iff (rst)
        (!win_open && req.wr) |=> (stub_q == $past(req.data)));
endmodule

// File: rtl/ide_cfg_window.sv
module ide_cfg_window
    import cfgwin_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_rd,
    input  logic          bus_wr,
    input  logic          bus_word,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic          strap_clk25,
    output logic          win_open,
    output logic [DW-1:0] drv0_rd_tim,
    output logic [DW-1:0] drv0_wr_tim,
    output logic [DW-1:0] drv1_rd_tim,
    output logic [DW-1:0] drv1_wr_tim,
    output logic [DW-1:0] misc_cfg,
    output logic          clk25_sel
);
    bus_req_t      req;
    timing_t       set_a, set_b, drv1_set;
    logic [DW-1:0] ctrl;

    always_comb begin
        req.rd   = bus_rd;
        req.wr   = bus_wr;
        req.word = bus_word;
        req.addr = bus_addr;
        req.data = bus_wdata;
    end

    cfgwin_unlock u_unlock (
        .clk      (clk),
        .rst      (rst),
        .req      (req),
        .win_open (win_open)
    );

    cfgwin_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .req       (req),
        .win_open  (win_open),
        .strap_pin (strap_clk25),
        .rdata     (bus_rdata),
        .set_a     (set_a),
        .set_b     (set_b),
        .ctrl      (ctrl),
        .misc      (misc_cfg),
        .strap     (clk25_sel)
    );

    assign drv1_set    = (ctrl == CTRL_SPLIT) ? set_b : set_a;
    assign drv0_rd_tim = set_a.rd;
    assign drv0_wr_tim = set_a.wr;
    assign drv1_rd_tim = drv1_set.rd;
    assign drv1_wr_tim = drv1_set.wr;
endmodule

// File: tb/ide_cfg_window_bench.sv
module ide_cfg_window_bench;
    localparam int CLK_PERIOD = 10;
    localparam logic [1:0] OP_RW = 2'd0, OP_RB = 2'd1, OP_WB = 2'd2, OP_WW = 2'd3;
    localparam int NVEC = 43;

    // {req[3:0], op[1:0], addr[2:0], data[7:0], expected read[7:0]}
    localparam logic [24:0] VEC [NVEC] = '{
        {4'd4,  OP_RB, 3'd5, 8'h00, 8'h00},  // R4 stub after reset
        {4'd4,  OP_WB, 3'd7, 8'h5A, 8'h00},  // R4
        {4'd4,  OP_RB, 3'd0, 8'h00, 8'h5A},  // R4
        {4'd2,  OP_RW, 3'd1, 8'h00, 8'h5A},  // R2
        {4'd2,  OP_RW, 3'd1, 8'h00, 8'h5A},  // R2
        {4'd2,  OP_WB, 3'd2, 8'h03, 8'h00},  // R2 opens
        {4'd7,  OP_RB, 3'd5, 8'h00, 8'h01},  // R7
        {4'd7,  OP_WB, 3'd5, 8'h00, 8'h00},  // R7 ignored
        {4'd7,  OP_RB, 3'd5, 8'h00, 8'h01},  // R7
        {4'd8,  OP_WB, 3'd0, 8'h11, 8'h00},  // R8
        {4'd8,  OP_WB, 3'd1, 8'h22, 8'h00},  // R8
        {4'd8,  OP_RB, 3'd0, 8'h00, 8'h11},  // R8
        {4'd8,  OP_RB, 3'd1, 8'h00, 8'h22},  // R8
        {4'd9,  OP_WB, 3'd6, 8'h01, 8'h00},  // R9 select B while disabled
        {4'd9,  OP_WB, 3'd0, 8'h33, 8'h00},  // R9 lands in A
        {4'd9,  OP_RB, 3'd0, 8'h00, 8'h33},  // R9
        {4'd5,  OP_RB, 3'd4, 8'h00, 8'h00},  // R5 unused index
        {4'd5,  OP_RW, 3'd0, 8'h00, 8'h00},  // R5 word read
        {4'd6,  OP_WW, 3'd2, 8'h83, 8'h00},  // R6 word write ignored
        {4'd6,  OP_WB, 3'd2, 8'h55, 8'h00},  // R6 other value ignored
        {4'd6,  OP_RB, 3'd6, 8'h00, 8'h01},  // R6 still open
        {4'd6,  OP_WB, 3'd2, 8'h83, 8'h00},  // R6 close
        {4'd6,  OP_RB, 3'd0, 8'h00, 8'h03},  // R6 stub again
        {4'd9,  OP_WB, 3'd3, 8'hC0, 8'h00},  // R9 enable B
        {4'd4,  OP_RB, 3'd1, 8'h00, 8'hC0},  // R4
        {4'd3,  OP_RW, 3'd1, 8'h00, 8'hC0},  // R3
        {4'd3,  OP_RB, 3'd1, 8'h00, 8'hC0},  // R3 breaks key
        {4'd3,  OP_RW, 3'd1, 8'h00, 8'hC0},  // R3
        {4'd3,  OP_WB, 3'd2, 8'h03, 8'h00},  // R3 no open
        {4'd3,  OP_RB, 3'd5, 8'h00, 8'h03},  // R3 still hidden
        {4'd2,  OP_RW, 3'd1, 8'h00, 8'h03},  // R2
        {4'd2,  OP_RW, 3'd1, 8'h00, 8'h03},  // R2
        {4'd2,  OP_RW, 3'd1, 8'h00, 8'h03},  // R2 third read
        {4'd2,  OP_WB, 3'd2, 8'h03, 8'h00},  // R2 opens
        {4'd2,  OP_RB, 3'd5, 8'h00, 8'h01},  // R2
        {4'd8,  OP_WB, 3'd0, 8'h44, 8'h00},  // R8 to B
        {4'd8,  OP_WB, 3'd1, 8'h55, 8'h00},  // R8 to B
        {4'd8,  OP_RB, 3'd0, 8'h00, 8'h44},  // R8
        {4'd8,  OP_WB, 3'd6, 8'h00, 8'h00},  // R8 back to A
        {4'd8,  OP_RB, 3'd0, 8'h00, 8'h33},  // R8
        {4'd8,  OP_RB, 3'd6, 8'h00, 8'h00},  // R8
        {4'd10, OP_WB, 3'd3, 8'h85, 8'h00},  // R10
        {4'd10, OP_RB, 3'd3, 8'h00, 8'h85}   // R10
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] bus_addr = '0;
    logic       bus_rd = 1'b0, bus_wr = 1'b0, bus_word = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       strap_clk25 = 1'b1;
    logic       win_open, clk25_sel;
    logic [7:0] drv0_rd_tim, drv0_wr_tim, drv1_rd_tim, drv1_wr_tim, misc_cfg;

    int checks = 0;
    int failures = 0;
    logic done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ide_cfg_window u_ide_cfg_window (
        .clk, .rst, .bus_addr, .bus_rd, .bus_wr, .bus_word, .bus_wdata, .bus_rdata,
        .strap_clk25, .win_open, .drv0_rd_tim, .drv0_wr_tim, .drv1_rd_tim,
        .drv1_wr_tim, .misc_cfg, .clk25_sel
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_op(input logic [1:0] op, input logic [2:0] a, input logic [7:0] d,
                         output logic [7:0] rd_val);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_word  = (op == OP_RW) || (op == OP_WW);
        bus_rd    = (op == OP_RW) || (op == OP_RB);
        bus_wr    = (op == OP_WB) || (op == OP_WW);
        #1 rd_val = bus_rdata;
        @(posedge clk);
        #1;
        bus_rd = 1'b0;
        bus_wr = 1'b0;
    endtask

    task automatic do_reset(input logic pin);
        @(negedge clk);
        strap_clk25 = pin;
        rst = 1'b1;
        repeat (2) @(posedge clk);
        #1 rst = 1'b0;
    endtask

    initial begin
        for (int cyc = 0; cyc < 20000; cyc++) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [7:0] r;
        do_reset(1'b1);
        // R1 reset state
        chk("R1 win_open", {7'd0, win_open}, 8'h00);
        chk("R1 drv0_rd", drv0_rd_tim, 8'hFF);
        chk("R1 drv1_wr", drv1_wr_tim, 8'hFF);
        chk("R1 misc", misc_cfg, 8'h00);
        chk("R7 clk25_sel", {7'd0, clk25_sel}, 8'h01);

        for (int i = 0; i < NVEC; i++) begin
            logic [24:0] v;
            v = VEC[i];
            do_op(v[20:19], v[18:16], v[15:8], r);
            if (v[20:19] == OP_RW || v[20:19] == OP_RB)
                chk($sformatf("R%0d vec%0d", v[24:21], i), r, v[7:0]);
        end

        // R10 split mapping, set A still 33/22, set B 44/55
        chk("R10 drv0_rd", drv0_rd_tim, 8'h33);
        chk("R10 drv0_wr", drv0_wr_tim, 8'h22);
        chk("R10 drv1_rd", drv1_rd_tim, 8'h44);
        chk("R10 drv1_wr", drv1_wr_tim, 8'h55);
        do_op(OP_WB, 3'd3, 8'h00, r);
        chk("R10 drv1 shares A", drv1_rd_tim, 8'h33);

        // R6 close, then R3 idle gaps keep the tracker
        do_op(OP_WB, 3'd2, 8'h83, r);
        chk("R6 closed", {7'd0, win_open}, 8'h00);
        do_op(OP_RW, 3'd1, 8'h00, r);
        repeat (3) @(posedge clk);
        do_op(OP_RW, 3'd1, 8'h00, r);
        repeat (2) @(posedge clk);
        do_op(OP_WB, 3'd2, 8'h03, r);
        chk("R3 idle gap keeps key", {7'd0, win_open}, 8'h01);

        // R1 reset mid-run with strap low
        do_reset(1'b0);
        chk("R1 closed after reset", {7'd0, win_open}, 8'h00);
        chk("R1 drv0_wr slow", drv0_wr_tim, 8'hFF);
        chk("R1 drv1_rd slow", drv1_rd_tim, 8'hFF);
        chk("R7 strap low", {7'd0, clk25_sel}, 8'h00);
        do_op(OP_RB, 3'd0, 8'h00, r);
        chk("R1 stub cleared", r, 8'h00);
        // R1 set-B enable cleared: misc bit0 alone must keep writes in A
        do_op(OP_RW, 3'd1, 8'h00, r);
        do_op(OP_RW, 3'd1, 8'h00, r);
        do_op(OP_WB, 3'd2, 8'h03, r);
        do_op(OP_WB, 3'd6, 8'h01, r);
        do_op(OP_WB, 3'd0, 8'h77, r);
        chk("R1 B disabled after reset", drv0_rd_tim, 8'h77);
        do_op(OP_RB, 3'd5, 8'h00, r);
        chk("R7 strap read low", r, 8'h00);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule